// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Detection

This block receives asynchronous serial characters on a single line. A clock divider makes an oversampling tick at sixteen times the bit rate. A state machine finds the start bit, samples each bit three times near its centre and takes the majority of the three samples. It then delivers an 8-bit or 9-bit character with a data-ready flag. When parity checking is enabled, the top bit of the character is the parity bit, and a mismatch sets a parity-error flag.

A separate counter watches the line for an idle period. An idle period is a whole character time of continuous high level: 10 bit times in 8-bit mode and 11 bit times in 9-bit mode. A select input sets where the count starts. It can start right after the start bit, so the trailing one bits and the stop bit count. It can also start only after the stop bit. The idle flag can set once per idle period. After that it stays armed off until a new character has been received. One clear pulse from the host clears all three flags. A single interrupt request combines the data-ready flag and the idle flag, each through its own enable.

The state machine has four states:
- **WATCH**: the line is idle.
- **START**: the start bit is being confirmed.
- **DATA**: data bits are being shifted in.
- **STOP**: the stop bit is in progress, and the character is delivered here.

The transitions are:
- WATCH→START: a low sample is seen on a tick.
- START→WATCH: the majority of the three mid-bit samples is high (glitch reject).
- START→DATA: the start bit ends.
- DATA→DATA: the next bit begins.
- DATA→STOP: the last data bit ends.
- STOP→WATCH: the stop bit ends.

Top module: `uart_idle_rx`

## Requirements
- R1: In 8-bit mode (`nine_bit`=0), eight bits following the start bit are received LSB first into `rx_data[7:0]`, and `rx_data[8]` reads 0.
- R2: In 9-bit mode (`nine_bit`=1), nine bits are received LSB first into `rx_data[8:0]`.
- R3: `rdf` rises during the stop bit of every accepted character and clears on a one-cycle `flag_clr` pulse. A delivery in the same cycle as a clear takes priority.
- R4: With `par_en`=1, `perr` is set on delivery when the count of ones in the character does not match the selected parity. The count covers the parity bit: 8 bits in 8-bit mode and 9 bits in 9-bit mode. `par_odd`=0 selects even parity and 1 selects odd parity.
- R5: With `par_en`=0, `perr` stays 0 whatever the character holds.
- R6: Each bit is resolved by majority vote of oversample counts 7, 8 and 9. A start bit whose vote is high is dropped as a glitch, and no character is delivered.
- R7: With `idle_after_stop`=0, `idle` sets after 10 (8-bit) or 11 (9-bit) bit times of continuous high line, counted from the end of the start bit.
- R8: With `idle_after_stop`=1, the same high time is counted only from the end of the stop bit.
- R9: After `idle` has set once, it cannot set again until a new character has been received. Out of reset it stays 0 until the first character has arrived.
- R10: `irq` is high when (`rdf` and `rie`) or (`idle` and `ilie`).
- R11: After reset all flags, `rx_data` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Asynchronous serial line, idle high |
| nine_bit | input | 1 | 1: 9-bit characters, 0: 8-bit |
| par_en | input | 1 | Enables the parity check on the character's top bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| idle_after_stop | input | 1 | 1: idle count starts after the stop bit, 0: after the start bit |
| rie | input | 1 | Interrupt enable for the data-ready flag |
| ilie | input | 1 | Interrupt enable for the idle flag |
| flag_clr | input | 1 | One-cycle pulse that clears `rdf`, `perr` and `idle` |
| rx_data | output | 9 | Last received character |
| rdf | output | 1 | Receive data full flag |
| perr | output | 1 | Parity error flag |
| idle | output | 1 | Idle line flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `CLK_DIV`=2, so a bit lasts 32 clocks. This makes it affordable to sweep every 8-bit value, with data length, parity enable, parity type and interrupt enable changing together with the data, so each parity outcome is reached in both modes. The short bit time also allows idle windows to be probed a few bit times before and after the expected threshold, for both start points and both lengths. The same setting is used for a start glitch that is only two ticks long.

// File: rtl/uart_idle_rx_pkg.sv
package uart_idle_rx_pkg;
    typedef enum logic [1:0] {
        ST_WATCH,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_os_tick.sv
module uart_os_tick #(
    parameter int CLK_DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_idle_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       nine_bit,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       flag_clr,
    output logic [8:0] rx_data,
    output logic       rdf,
    output logic       perr,
    output logic       in_watch,
    output logic       char_done
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2);
    localparam logic [CW-1:0] S_LO = MID - 1'b1;
    localparam logic [CW-1:0] S_HI = MID + 1'b1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t state, nxt;
    logic [CW-1:0] os_cnt;
    logic [3:0]    bit_idx;
    logic [8:0]    shreg;
    logic          smp_a, smp_b;
    logic          vote, vote_pt, bit_end, last_bit, ones_par, deliver;

    assign vote     = (smp_a & smp_b) | (smp_a & rx_s) | (smp_b & rx_s);
    assign vote_pt  = tick && (os_cnt == S_HI);
    assign bit_end  = tick && (os_cnt == LAST);
    assign last_bit = (bit_idx == (nine_bit ? 4'd8 : 4'd7));
    assign deliver  = (state == ST_STOP) && vote_pt;
    assign ones_par = nine_bit ? ^shreg : ^shreg[7:0];

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WATCH: if (tick && !rx_s) nxt = ST_START;
            ST_START: begin
                if (vote_pt && vote) nxt = ST_WATCH;
                else if (bit_end)    nxt = ST_DATA;
            end
            ST_DATA:  if (bit_end && last_bit) nxt = ST_STOP;
            ST_STOP:  if (bit_end) nxt = ST_WATCH;
            default:  nxt = ST_WATCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WATCH;
        else        state <= nxt;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt  <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            smp_a   <= 1'b1;
            smp_b   <= 1'b1;
            rx_data <= '0;
            rdf     <= 1'b0;
            perr    <= 1'b0;
        end else begin
            if (tick) begin
                if (state == ST_WATCH) begin
                    os_cnt <= rx_s ? '0 : CW'(1);
                end else begin
                    os_cnt <= os_cnt + 1'b1;
                end
                if (os_cnt == S_LO) smp_a <= rx_s;
                if (os_cnt == MID)  smp_b <= rx_s;
            end
            if (state == ST_START && bit_end) begin
                bit_idx <= '0;
                shreg   <= '0;
            end
            if (state == ST_DATA) begin
                if (vote_pt) shreg[bit_idx] <= vote;
                if (bit_end && !last_bit) bit_idx <= bit_idx + 1'b1;
            end
            if (deliver) begin
                rx_data <= nine_bit ? shreg : {1'b0, shreg[7:0]};
                rdf     <= 1'b1;
                perr    <= par_en & (ones_par ^ par_odd);
            end else if (flag_clr) begin
                rdf  <= 1'b0;
                perr <= 1'b0;
            end
        end
    end

    assign in_watch  = (state == ST_WATCH);
    assign char_done = deliver;

    p_deliver_in_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdf) |-> $past(state == ST_STOP));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !deliver |=> !rdf && !perr);
    p_no_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        deliver && !par_en |=> !perr);
    p_glitch_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) && vote_pt && vote |=> state == ST_WATCH);
endmodule

// File: rtl/uart_idle_det.sv
module uart_idle_det #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_s,
    input  logic nine_bit,
    input  logic idle_after_stop,
    input  logic in_watch,
    input  logic char_done,
    input  logic flag_clr,
    output logic idle
);
    localparam int LIM8 = 10 * OSR;
    localparam int LIM9 = 11 * OSR;
    localparam int IW   = $clog2(LIM9 + 1);

    logic [IW-1:0] hi_cnt;
    logic [IW-1:0] limit;
    logic          armed, hit;

    assign limit = nine_bit ? IW'(LIM9) : IW'(LIM8);
    assign hit   = (hi_cnt >= limit) && rx_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            armed  <= 1'b0;
            idle   <= 1'b0;
        end else begin
            if (idle_after_stop && !in_watch) begin
                hi_cnt <= '0;
            end else if (tick) begin
                if (!rx_s)               hi_cnt <= '0;
                else if (hi_cnt < limit) hi_cnt <= hi_cnt + 1'b1;
            end
            if (char_done) begin
                armed <= 1'b1;
            end else if (armed && hit) begin
                armed <= 1'b0;
            end
            if (armed && hit && !char_done) idle <= 1'b1;
            else if (flag_clr)              idle <= 1'b0;
        end
    end

    p_idle_on_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(rx_s));
    p_idle_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> !armed);
endmodule

// File: rtl/uart_idle_rx.sv
module uart_idle_rx #(
    parameter int CLK_DIV = 27,
    parameter int OSR     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx,
    input  logic       nine_bit,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       idle_after_stop,
    input  logic       rie,
    input  logic       ilie,
    input  logic       flag_clr,
    output logic [8:0] rx_data,
    output logic       rdf,
    output logic       perr,
    output logic       idle,
    output logic       irq
);
    logic [1:0] sync_q;
    logic       rx_s, tick, in_watch, char_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx};
    end
    assign rx_s = sync_q[1];

    uart_os_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk (clk),
        .rst_n (rst_n),
        .tick (tick)
    );

    uart_rx_fsm #(.OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_s      (rx_s),
        .nine_bit  (nine_bit),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .flag_clr  (flag_clr),
        .rx_data   (rx_data),
        .rdf       (rdf),
        .perr      (perr),
        .in_watch  (in_watch),
        .char_done (char_done)
    );

    uart_idle_det #(.OSR(OSR)) u_idle (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .rx_s            (rx_s),
        .nine_bit        (nine_bit),
        .idle_after_stop (idle_after_stop),
        .in_watch        (in_watch),
        .char_done       (char_done),
        .flag_clr        (flag_clr),
        .idle            (idle)
    );

    assign irq = (rdf & rie) | (idle & ilie);

    p_irq_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdf && rie |-> irq);
    p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle && ilie |-> irq);
endmodule

// File: tb/uart_idle_rx_test.sv
`timescale 1ns/1ps
module uart_idle_rx_test;
    localparam int DIV = 2;
    localparam int BIT = DIV * 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       idle_after_stop = 1'b0, rie = 1'b0, ilie = 1'b0, flag_clr = 1'b0;
    logic [8:0] rx_data;
    logic       rdf, perr, idle, irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_idle_rx #(.CLK_DIV(DIV), .OSR(16)) uut (
        .clk (clk), .rst_n (rst_n), .rx (rx),
        .nine_bit (nine_bit), .par_en (par_en), .par_odd (par_odd),
        .idle_after_stop (idle_after_stop), .rie (rie), .ilie (ilie),
        .flag_clr (flag_clr), .rx_data (rx_data), .rdf (rdf),
        .perr (perr), .idle (idle), .irq (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] v, input logic nine);
        rx = 1'b0;
        wait_clk(BIT);
        for (int b = 0; b < (nine ? 9 : 8); b++) begin
            rx = v[b];
            wait_clk(BIT);
        end
        rx = 1'b1;
        wait_clk(BIT);
    endtask

    task automatic clear();
        flag_clr = 1'b1;
        wait_clk(1);
        flag_clr = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        wait_clk(200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        // R11 reset state
        chk("R11 rdf", rdf, 0);
        chk("R11 perr", perr, 0);
        chk("R11 idle", idle, 0);
        chk("R11 irq", irq, 0);
        chk("R11 rx_data", rx_data, 0);
        rst_n = 1'b1;
        wait_clk(4 * BIT);
        // R9: no idle before any character arrives
        chk("R9 idle before first char", idle, 0);

        // R6: glitch on the start bit of two ticks
        rx = 1'b0;
        wait_clk(2 * DIV);
        rx = 1'b1;
        wait_clk(12 * BIT);
        chk("R6 glitch no rdf", rdf, 0);

        // sweep: R1 R2 R3 R4 R5 R10
        for (int i = 0; i < 256; i++) begin
            logic [8:0] v;
            logic       ones, ep;
            nine_bit = i[2];
            par_en   = i[0];
            par_odd  = i[1];
            rie      = i[4];
            ilie     = 1'b0;
            v = nine_bit ? {i[3] ^ i[5], i[7:0]} : {1'b0, i[7:0]};
            wait_clk(1);
            send(v, nine_bit);
            ones = nine_bit ? ^v : ^v[7:0];
            ep   = par_en & (ones ^ par_odd);
            chk(nine_bit ? "R2 data" : "R1 data", rx_data, v);
            chk("R3 rdf set", rdf, 1);
            chk(par_en ? "R4 perr" : "R5 perr", perr, ep);
            chk("R10 irq data", irq, rie);
            clear();
            chk("R3 rdf clear", rdf, 0);
            wait_clk(BIT);
        end
        clear();
        rie  = 1'b0;
        ilie = 1'b1;
        par_en = 1'b0;

        // R7: count from after start bit, 8-bit, all ones
        nine_bit = 1'b0; idle_after_stop = 1'b0;
        wait_clk(14 * BIT); clear();
        send(9'h0FF, 1'b0); clear();
        wait_clk(3 * BIT);
        chk("R7 idle ones early", idle, 1);
        chk("R10 irq idle", irq, 1);
        clear();
        wait_clk(12 * BIT);
        chk("R9 no second idle", idle, 0);

        // R7: all zeros, only stop bit counts
        send(9'h000, 1'b0); clear();
        wait_clk(3 * BIT);
        chk("R7 idle zeros early", idle, 0);
        wait_clk(9 * BIT);
        chk("R7 idle zeros late", idle, 1);
        clear();

        // R8: count after stop bit, 8-bit
        idle_after_stop = 1'b1;
        send(9'h0FF, 1'b0); clear();
        wait_clk(9 * BIT);
        chk("R8 idle 8b early", idle, 0);
        wait_clk(3 * BIT);
        chk("R8 idle 8b late", idle, 1);
        clear();

        // R8 + R2: 9-bit, 11 bit times
        nine_bit = 1'b1;
        send(9'h1FF, 1'b1); clear();
        wait_clk(10 * BIT);
        chk("R8 idle 9b early", idle, 0);
        wait_clk(3 * BIT);
        chk("R8 idle 9b late", idle, 1);
        ilie = 1'b0;
        wait_clk(1);
        chk("R10 irq masked", irq, 0);

        // R7: 9-bit from start bit, all ones needs 11 bits
        clear();
        idle_after_stop = 1'b0;
        send(9'h1FF, 1'b1); clear();
        wait_clk(3 * BIT);
        chk("R7 idle 9b ones", idle, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule